// File: doc/BRIEF.md
# Datapath Fault Injector

This block sits inline on a 16-bit fixed-point stream and deliberately corrupts chosen bits of the words that pass through it. It is used to measure how well a neural-network datapath tolerates hardware faults. Each word is split into a sign bit, a small integer field and a fraction field. Software selects a fault kind, a target field and a number of bits, seeds a pseudo-random generator, and arms the injector. The injector then draws distinct random bit positions inside the chosen field. After that it applies stuck-at-0, stuck-at-1 or a one-word inversion to the traffic.

The stream has a valid/ready handshake and is held in a single output register, so every word reaches the output one cycle after it is accepted. Permanent faults stay in force until a clear pulse removes them. A transient fault corrupts exactly one word and then disarms itself. A sticky flag and a saturating event counter record corrupted words, and the clear pulse resets both.

Top module: `dp_fault_injector`

## Requirements
- R1: A word accepted while `in_valid` and `in_ready` are both high appears on `out_data` with `out_valid` high at the next clock edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold.
- R2: The word is laid out as sign = bit 15, digit = bits 14:12 and fraction = bits 11:0. `cfg_field` selects the target field: 0 any bit, 1 sign, 2 digit, 3 fraction. The fault mask never holds a bit outside the selected field.
- R3: The random source is a 16-bit shift-left register. Its new bit 0 is the XOR of bits 15, 13, 12 and 10. It resets to 16'hACE1. `seed_load` in idle loads `seed_value`, and a zero seed loads 1 instead. It advances once per pick cycle. The candidate index in that cycle is the field's lowest bit plus (state modulo field width), taken from the state before the advance.
- R4: The number of faulty bits is `cfg_count`, with 0 treated as 1, values above 4 treated as 4, and the result limited to the field width. A candidate already in the mask is skipped. The injector becomes armed in the cycle after the last distinct bit is picked.
- R5: `cfg_kind` 0 (stuck-at-0) clears every mask bit of every word accepted while armed, until a clear.
- R6: `cfg_kind` 1 (stuck-at-1) sets every mask bit of every word accepted while armed, until a clear.
- R7: `cfg_kind` 2 or 3 (transient) inverts the mask bits of only the first word accepted while armed. The injector is idle again in the next cycle.
- R8: Kind, field, count and seed are sampled only while the injector is idle. `arm` and `seed_load` have no effect while it is picking or armed.
- R9: A `clear` pulse leaves the injector idle with an empty mask, `injected` low and `inj_count` zero in the next cycle. A word accepted in the same cycle as the clear passes unchanged.
- R10: Each word corrupted while armed sets `injected` and increments `inj_count`, which saturates at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_kind | input | 2 | Fault kind: 0 stuck-at-0, 1 stuck-at-1, 2/3 transient |
| cfg_field | input | 2 | Target field: 0 any, 1 sign, 2 digit, 3 fraction |
| cfg_count | input | 3 | Requested number of faulty bits |
| seed_load | input | 1 | Load the random source (idle only) |
| seed_value | input | 16 | Seed value |
| arm | input | 1 | Start bit selection (idle only) |
| clear | input | 1 | Drop all faults, reset flag and counter |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be accepted |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 16 | Output word, possibly corrupted |
| armed | output | 1 | Fault mask is active |
| injected | output | 1 | Sticky: a word has been corrupted |
| inj_count | output | 16 | Number of corrupted words, saturating |

## Verification
The embedded properties assume nothing about the input protocol. `in_valid` may drop without a transfer, data may change at any time, and `out_ready` may stall at any cycle. The stimulus therefore draws valid, data and ready at random on every cycle. The properties do assume that control pulses arrive one cycle at a time from the idle state. The stimulus keeps to that by issuing `arm`, `seed_load` and `clear` as single-cycle pulses, including pulses deliberately sent while the injector is busy. The stimulus also covers out-of-range counts (0 and 7), a zero seed, and clears that land in the same cycle as an accepted word.

// File: rtl/dp_fault_injector.sv
module dp_fault_injector #(
  parameter int DW = 16,
  parameter int INT_W = 3,
  parameter int MAX_FAULTS = 4,
  parameter logic [15:0] SEED_RST = 16'hACE1,
  localparam int CW = $clog2(MAX_FAULTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_kind,
  input  logic [1:0]    cfg_field,
  input  logic [CW-1:0] cfg_count,
  input  logic          seed_load,
  input  logic [15:0]   seed_value,
  input  logic          arm,
  input  logic          clear,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          armed,
  output logic          injected,
  output logic [15:0]   inj_count
);
  localparam int IW = $clog2(DW);
  localparam int FRAC_W = DW - 1 - INT_W;
  localparam int DIG_LO = FRAC_W;
  localparam int SIGN_POS = DW - 1;

  typedef enum logic [1:0] {S_IDLE, S_PICK, S_ARMED} st_t;

  st_t           st;
  logic [15:0]   lfsr;
  logic [DW-1:0] mask, od, hurt;
  logic [1:0]    kind_q, field_q;
  logic [CW-1:0] target, picked, picked_nx, arm_target;
  logic          ov, inj_q, acc, hit, new_bit;
  logic [15:0]   cnt, lfsr_nx;
  logic [IW-1:0] cand;

  function automatic int field_width(logic [1:0] f);
    case (f)
      2'd0:    return DW;
      2'd1:    return 1;
      2'd2:    return INT_W;
      default: return FRAC_W;
    endcase
  endfunction

  function automatic logic [DW-1:0] field_mask(logic [1:0] f);
    logic [DW-1:0] m;
    for (int b = 0; b < DW; b++) begin
      case (f)
        2'd0:    m[b] = 1'b1;
        2'd1:    m[b] = (b == SIGN_POS);
        2'd2:    m[b] = (b >= DIG_LO) && (b < SIGN_POS);
        default: m[b] = (b < FRAC_W);
      endcase
    end
    return m;
  endfunction

  assign in_ready  = !ov || out_ready;
  assign acc       = in_valid && in_ready;
  assign hit       = acc && (st == S_ARMED) && !clear;
  assign out_valid = ov;
  assign out_data  = od;
  assign armed     = (st == S_ARMED);
  assign injected  = inj_q;
  assign inj_count = cnt;
  assign lfsr_nx   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign new_bit   = !mask[cand];
  assign picked_nx = picked + CW'(new_bit);

  always_comb begin
    case (field_q)
      2'd0:    cand = IW'(32'(lfsr) % DW);
      2'd1:    cand = IW'(SIGN_POS);
      2'd2:    cand = IW'(DIG_LO + int'(32'(lfsr) % INT_W));
      default: cand = IW'(32'(lfsr) % FRAC_W);
    endcase
  end

  always_comb begin
    int n;
    n = int'(cfg_count);
    if (n < 1) n = 1;
    if (n > MAX_FAULTS) n = MAX_FAULTS;
    if (n > field_width(cfg_field)) n = field_width(cfg_field);
    arm_target = CW'(n);
  end

  always_comb begin
    case (kind_q)
      2'd0:    hurt = in_data & ~mask;
      2'd1:    hurt = in_data | mask;
      default: hurt = in_data ^ mask;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov <= 1'b0;
      od <= '0;
    end else if (acc) begin
      ov <= 1'b1;
      od <= hit ? hurt : in_data;
    end else if (out_ready) begin
      ov <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_q <= 1'b0;
      cnt   <= '0;
    end else if (clear) begin
      inj_q <= 1'b0;
      cnt   <= '0;
    end else if (hit) begin
      inj_q <= 1'b1;
      cnt   <= cnt + 16'(cnt != 16'hFFFF);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lfsr    <= SEED_RST;
      mask    <= '0;
      kind_q  <= '0;
      field_q <= '0;
      target  <= CW'(1);
      picked  <= '0;
    end else if (clear) begin
      st   <= S_IDLE;
      mask <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (seed_load) lfsr <= (seed_value == 16'h0) ? 16'h1 : seed_value;
          if (arm) begin
            kind_q  <= cfg_kind;
            field_q <= cfg_field;
            target  <= arm_target;
            picked  <= '0;
            mask    <= '0;
            st      <= S_PICK;
          end
        end
        S_PICK: begin
          if (new_bit) mask[cand] <= 1'b1;
          picked <= picked_nx;
          lfsr   <= lfsr_nx;
          if (picked_nx == target) st <= S_ARMED;
        end
        default: begin
          if (kind_q[1] && hit) begin
            st   <= S_IDLE;
            mask <= '0;
          end
        end
      endcase
    end
  end

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_mask_in_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~field_mask(field_q)) == '0);

  assert_seed_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0);

  assert_distinct_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> $countones(mask) == int'(target));

  assert_transient_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && kind_q[1] && in_valid && in_ready && !clear |=> !armed && mask == '0);

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_IDLE && !clear |=> $stable(kind_q) && $stable(field_q) && $stable(target));

  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !armed && !injected && inj_count == 16'h0 && mask == '0);

  assert_sticky_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    injected && !clear |=> injected);
endmodule

// File: tb/tb_dp_fault_injector.sv
module tb_dp_fault_injector;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, seed_load, arm, clear, in_valid, in_ready, out_valid, out_ready;
  logic armed, injected;
  logic [1:0] cfg_kind, cfg_field;
  logic [2:0] cfg_count;
  logic [15:0] seed_value, in_data, out_data, inj_count;

  dp_fault_injector dut (
    .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_field(cfg_field),
    .cfg_count(cfg_count), .seed_load(seed_load), .seed_value(seed_value),
    .arm(arm), .clear(clear), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .armed(armed), .injected(injected), .inj_count(inj_count)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  bit live = 0, done = 0;
  string tag = "R1";

  int m_st, m_kind, m_field, m_target, m_picked, m_cnt;
  logic [15:0] m_lfsr, m_mask, m_od;
  bit m_ov, m_inj;

  function automatic int fw(int f);
    if (f == 0) return 16;
    if (f == 1) return 1;
    if (f == 2) return 3;
    return 12;
  endfunction
  function automatic int flo(int f);
    if (f == 1) return 15;
    if (f == 2) return 12;
    return 0;
  endfunction
  function automatic logic [15:0] fmask(int f);
    if (f == 0) return 16'hFFFF;
    if (f == 1) return 16'h8000;
    if (f == 2) return 16'h7000;
    return 16'h0FFF;
  endfunction
  function automatic int tgt(int c, int f);
    int n = c;
    if (n < 1) n = 1;
    if (n > 4) n = 4;
    if (n > fw(f)) n = fw(f);
    return n;
  endfunction

  task automatic chk(string t, logic [31:0] a, logic [31:0] e);
    compared++;
    if (a !== e) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", t, a, e);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_lfsr = 16'hACE1; m_mask = 0; m_kind = 0; m_field = 0;
      m_target = 1; m_picked = 0; m_ov = 0; m_od = 0; m_inj = 0; m_cnt = 0;
    end else begin
      bit acc, hit;
      logic [15:0] d;
      int cand;
      acc = in_valid && (!m_ov || out_ready);
      hit = acc && m_st == 2 && !clear;
      d = in_data;
      if (hit) begin
        if (m_kind == 0) d = d & ~m_mask;
        else if (m_kind == 1) d = d | m_mask;
        else d = d ^ m_mask;
      end
      if (acc) begin m_od = d; m_ov = 1; end
      else if (out_ready) m_ov = 0;
      if (clear) begin m_inj = 0; m_cnt = 0; end
      else if (hit) begin m_inj = 1; if (m_cnt < 65535) m_cnt++; end
      if (clear) begin m_st = 0; m_mask = 0; end
      else if (m_st == 0) begin
        if (seed_load) m_lfsr = (seed_value == 0) ? 16'h1 : seed_value;
        if (arm) begin
          m_kind = cfg_kind; m_field = cfg_field; m_target = tgt(cfg_count, cfg_field);
          m_picked = 0; m_mask = 0; m_st = 1;
        end
      end else if (m_st == 1) begin
        cand = flo(m_field) + int'(m_lfsr % fw(m_field));
        if (!m_mask[cand]) begin m_mask[cand] = 1'b1; m_picked++; end
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        if (m_picked == m_target) m_st = 2;
      end else if (m_kind >= 2 && hit) begin
        m_st = 0; m_mask = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R1 out_valid", out_valid, m_ov);
      chk("R1 in_ready", in_ready, !m_ov || out_ready);
      if (m_ov) chk({tag, " out_data"}, out_data, m_od);
      chk({tag, " armed"}, armed, m_st == 2);
      chk("R10 injected", injected, m_inj);
      chk("R10 inj_count", inj_count, m_cnt);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic quiet();
    arm = 0; clear = 0; seed_load = 0;
  endtask

  task automatic stream(int n, int mode, int clr_rate);
    repeat (n) begin
      @(posedge clk); #2;
      quiet();
      in_valid = ($urandom % 4) != 0;
      in_data = (mode == 1) ? 16'h0 : (mode == 2) ? 16'hFFFF : 16'($urandom);
      out_ready = ($urandom % 4) != 0;
      if (clr_rate > 0) clear = ($urandom % clr_rate) == 0;
    end
  endtask

  task automatic arm_cfg(int k, int f, int c);
    @(posedge clk); #2;
    quiet(); in_valid = 0;
    cfg_kind = 2'(k); cfg_field = 2'(f); cfg_count = 3'(c); arm = 1;
    @(posedge clk); #2;
    arm = 0;
  endtask

  task automatic load_seed(logic [15:0] v);
    @(posedge clk); #2;
    quiet(); in_valid = 0; seed_value = v; seed_load = 1;
    @(posedge clk); #2;
    seed_load = 0;
  endtask

  task automatic do_clear();
    @(posedge clk); #2;
    quiet(); in_valid = 0; clear = 1;
    @(posedge clk); #2;
    clear = 0;
  endtask

  task automatic wait_armed();
    int k = 0;
    while (m_st != 2 && k < 500) begin stream(1, 0, 0); k++; end
    in_valid = 0;
    chk({tag, " reached armed"}, m_st == 2, 1);
  endtask

  task automatic probe(input logic [15:0] d, output logic [15:0] q);
    @(posedge clk); #2;
    quiet(); in_valid = 1; in_data = d; out_ready = 1;
    @(posedge clk); #2;
    in_valid = 0;
    @(negedge clk);
    q = out_data;
  endtask

  initial begin
    logic [15:0] q, q2;
    rst_n = 0; quiet(); in_valid = 0; in_data = 0; out_ready = 1;
    cfg_kind = 0; cfg_field = 0; cfg_count = 1; seed_value = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset in_ready", in_ready, 1);
    chk("R10 reset injected", injected, 0);
    chk("R10 reset inj_count", inj_count, 0);
    chk("R8 reset armed", armed, 0);
    @(posedge clk); #2;
    rst_n = 1; live = 1;

    tag = "R1"; stream(200, 0, 0);

    tag = "R3"; load_seed(16'h1234); arm_cfg(1, 0, 1); wait_armed();
    probe(16'h0, q); chk("R3 seed 1234 picks bit 4", q, 16'h0010);
    do_clear();

    tag = "R6"; arm_cfg(1, 3, 3); wait_armed();
    probe(16'h0, q);
    chk("R6 stuck-at-1 bit count", $countones(q), 3);
    chk("R2 fraction-only mask", q & ~fmask(3), 0);
    stream(300, 1, 0); stream(200, 0, 0);

    tag = "R8"; arm_cfg(0, 1, 1); load_seed(16'h0);
    probe(16'h0, q2);
    chk("R8 arm while armed ignored", q2, q);
    chk("R8 still armed", armed, 1);

    tag = "R9"; stream(400, 0, 40);
    do_clear();
    chk("R9 flag cleared", injected, 0);
    chk("R9 counter cleared", inj_count, 0);
    probe(16'h0, q); chk("R9 no fault after clear", q, 16'h0);

    tag = "R5"; arm_cfg(0, 2, 4); wait_armed();
    probe(16'hFFFF, q); chk("R5 stuck-at-0 whole digit field (R4 width limit)", q, 16'h8FFF);
    stream(300, 2, 0); stream(200, 0, 0);
    do_clear();

    tag = "R10"; arm_cfg(1, 1, 2); wait_armed();
    repeat (3) begin
      probe(16'h0, q); chk("R2 sign-only stuck-at-1", q, 16'h8000);
    end
    chk("R10 three corrupted words", inj_count, 3);
    chk("R10 sticky flag", injected, 1);

    tag = "R7"; do_clear(); arm_cfg(2, 3, 2); wait_armed();
    probe(16'h0, q); chk("R7 transient bits", $countones(q), 2);
    chk("R2 transient in fraction", q & ~fmask(3), 0);
    probe(16'h0, q); chk("R7 second word untouched", q, 16'h0);
    chk("R7 disarmed", armed, 0);

    load_seed(16'h0); arm_cfg(3, 0, 0); wait_armed();
    probe(16'h0, q); chk("R3 zero seed acts as 1", q, 16'h0002);
    probe(16'h0, q); chk("R7 kind 3 only once", q, 16'h0);

    tag = "R4"; arm_cfg(1, 0, 7); wait_armed();
    probe(16'h0, q); chk("R4 count 7 clamps to 4", $countones(q), 4);
    stream(500, 0, 0);
    stream(300, 0, 60);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule